// File: doc/BRIEF.md
# Display RAM Write Address Sequencer

This block produces the write address for the display data RAM of a matrix LCD driver that has 128 columns. The RAM is split into six row banks. Banks 0 to 4 hold pixel data and bank 5 holds icon data. A host front end that has already decoded the serial bus drives two inputs into the block. The first is a command port that carries an opcode and a small data field. The second is a data-write strobe. For each strobe the block issues a one-cycle RAM write enable together with the current bank and column. It then moves its pointer to the next location.

Two stepping orders are available, and a direction bit chooses between them. In column-first order the pointer moves along a bank and then drops to the next pixel bank. In bank-first order the pointer moves down through the five pixel banks and then moves to the next column. The icon bank always uses column-first stepping, whatever the direction bit says, and the pointer never leaves bank 5 on its own. The function-set command also stores a power-down bit and an icon-mode bit. A multiplex-rate code and a display-mode code are kept as plain stored values for neighbouring logic.

Top module: `lcd_ram_addr_seq`

## Requirements
- R1: After reset, the column pointer is 0, the bank pointer is 0, the direction bit is 0, the icon-mode bit is 0, the multiplex code is 00, the display code is 00, the power-down output is 1 and ram_we is 0.
- R2: A cycle with wr_strobe high causes ram_we to be high for exactly the following cycle. In that cycle ram_bank and ram_col show the pointer as it stood before the increment. Each strobe cycle gives its own one-cycle pulse.
- R3: When the direction bit is 0 and the bank is a pixel bank (0 to 4), each write increments the column. After column 127 the column returns to 0 and the bank advances by one. Bank 4 wraps to bank 0.
- R4: When the direction bit is 1 and the bank is a pixel bank, each write increments the bank. After bank 4 the bank returns to 0 and the column increments. Column 127 wraps to 0.
- R5: When the bank is 5 (icon), each write increments the column, whatever the direction bit. After column 127 the column returns to 0 and the bank stays at 5.
- R6: Opcode 1 (set column) loads the column from cmd_data[6:0]. Opcode 2 (set bank) loads the bank from cmd_data[2:0] when that value is 0 to 5. The values 6 and 7 are ignored and the previous bank is kept.
- R7: Opcode 0 (function set) stores power-down from cmd_data[2], the direction bit from cmd_data[1] and icon mode from cmd_data[0]. While power-down is 1, writes and commands are still carried out.
- R8: Opcode 3 stores the multiplex code from cmd_data[1:0] (00 = 1:17, 01 = 1:26, 10 = 1:34). Opcode 4 stores the display code from cmd_data[1:0]. Opcodes 5 to 7 change no state.
- R9: When a command and a write strobe fall in the same cycle, the write uses the pointer from before the command. A set-column or set-bank command then takes priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 7 | Command data field |
| wr_strobe | input | 1 | Display data write request |
| ram_we | output | 1 | RAM write enable, one cycle per strobe |
| ram_bank | output | 3 | RAM bank for the write |
| ram_col | output | 7 | RAM column for the write |
| power_down | output | 1 | Stored power-down bit |
| vert_mode | output | 1 | Stored direction bit (1 = bank-first) |
| icon_mode | output | 1 | Stored icon-mode bit |
| mux_rate | output | 2 | Stored multiplex code |
| disp_mode | output | 2 | Stored display code |

## Verification
The hardest point to reach is the double wrap. The pointer is at the last pixel bank and column 127, so both coordinates must roll over at once. In bank-first order the column must also wrap from 127 to 0. Getting there from reset takes hundreds of writes. The stimulus therefore sweeps all 640 pixel locations in column-first order and continues past the end. It then presets the column near 127 with the set-column command and runs bank-first writes across the column wrap. Icon writes also start near column 127, so that the wrap happens while bank 5 must hold.

// File: rtl/lcd_ram_addr_seq.sv
module lcd_ram_addr_seq #(
  parameter int COLS      = 128,
  parameter int PIX_BANKS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [$clog2(COLS)-1:0]    cmd_data,
  input  logic                       wr_strobe,
  output logic                       ram_we,
  output logic [2:0]                 ram_bank,
  output logic [$clog2(COLS)-1:0]    ram_col,
  output logic                       power_down,
  output logic                       vert_mode,
  output logic                       icon_mode,
  output logic [1:0]                 mux_rate,
  output logic [1:0]                 disp_mode
);
  localparam int XW = $clog2(COLS);
  localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
  localparam logic [2:0] LASTP = 3'(PIX_BANKS - 1);
  localparam logic [2:0] ICON  = 3'(PIX_BANKS);

  localparam logic [2:0] OP_FUNC = 3'd0;
  localparam logic [2:0] OP_SETX = 3'd1;
  localparam logic [2:0] OP_SETY = 3'd2;
  localparam logic [2:0] OP_MUX  = 3'd3;
  localparam logic [2:0] OP_DISP = 3'd4;

  logic [XW-1:0] x_q, x_n, x_wrap;
  logic [2:0]    y_q, y_n;
  logic          v_q;

  assign vert_mode = v_q;
  assign x_wrap    = (x_q == XMAX) ? '0 : x_q + XW'(1);

  always_comb begin
    x_n = x_q;
    y_n = y_q;
    if (y_q == ICON) begin
      x_n = x_wrap;
    end else if (!v_q) begin
      x_n = x_wrap;
      if (x_q == XMAX) y_n = (y_q == LASTP) ? 3'd0 : y_q + 3'd1;
    end else begin
      if (y_q == LASTP) begin
        y_n = 3'd0;
        x_n = x_wrap;
      end else begin
        y_n = y_q + 3'd1;
      end
    end
  end

  wire set_x = cmd_valid && cmd_op == OP_SETX;
  wire set_y = cmd_valid && cmd_op == OP_SETY && cmd_data[2:0] <= ICON;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q        <= '0;
      y_q        <= 3'd0;
      v_q        <= 1'b0;
      power_down <= 1'b1;
      icon_mode  <= 1'b0;
      mux_rate   <= 2'b00;
      disp_mode  <= 2'b00;
      ram_we     <= 1'b0;
      ram_bank   <= 3'd0;
      ram_col    <= '0;
    end else begin
      ram_we <= wr_strobe;
      if (wr_strobe) begin
        ram_bank <= y_q;
        ram_col  <= x_q;
      end
      if (set_x)           x_q <= cmd_data;
      else if (wr_strobe)  x_q <= x_n;
      if (set_y)           y_q <= cmd_data[2:0];
      else if (wr_strobe)  y_q <= y_n;
      if (cmd_valid) begin
        case (cmd_op)
          OP_FUNC: begin
            power_down <= cmd_data[2];
            v_q        <= cmd_data[1];
            icon_mode  <= cmd_data[0];
          end
          OP_MUX:  mux_rate  <= cmd_data[1:0];
          OP_DISP: disp_mode <= cmd_data[1:0];
          default: ;
        endcase
      end
    end
  end

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(wr_strobe)); // R2
  AST_WE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> (ram_col == $past(x_q) && ram_bank == $past(y_q))); // R2
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    y_q <= ICON); // R6
  AST_BAD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SETY && cmd_data[2:0] > ICON && !wr_strobe) |=> $stable(y_q)); // R6
  AST_ICON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !cmd_valid && y_q == ICON) |=> y_q == ICON); // R5
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !cmd_valid && !v_q && y_q == LASTP && x_q == XMAX) |=> (x_q == '0 && y_q == 3'd0)); // R3
  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !cmd_valid && v_q && y_q < LASTP) |=> ($stable(x_q) && y_q == $past(y_q) + 3'd1)); // R4
endmodule

// File: tb/tb_lcd_ram_addr_seq.sv
module tb_lcd_ram_addr_seq;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, wr_strobe = 0;
  logic [2:0] cmd_op = 0;
  logic [6:0] cmd_data = 0;
  logic ram_we, power_down, vert_mode, icon_mode;
  logic [2:0] ram_bank;
  logic [6:0] ram_col;
  logic [1:0] mux_rate, disp_mode;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  lcd_ram_addr_seq dut (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_data, .wr_strobe,
    .ram_we, .ram_bank, .ram_col, .power_down, .vert_mode, .icon_mode, .mux_rate, .disp_mode);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(int op, int data);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_data = 7'(data);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wr(string req, int bank, int col);
    @(negedge clk);
    wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
    chk({req, " we"}, int'(ram_we), 1);
    chk({req, " bank"}, int'(ram_bank), bank);
    chk({req, " col"}, int'(ram_col), col);
  endtask

  initial begin
    #45 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pd", int'(power_down), 1);
    chk("R1 v", int'(vert_mode), 0);
    chk("R1 im", int'(icon_mode), 0);
    chk("R1 mux", int'(mux_rate), 0);
    chk("R1 disp", int'(disp_mode), 0);
    chk("R1 we", int'(ram_we), 0);
    // R7 writes accepted under power-down; also first pointer is 0,0 (R1)
    wr("R7 R1 pd write", 0, 0);
    @(negedge clk);
    chk("R2 we drops", int'(ram_we), 0);
    // R3 full horizontal sweep from 0,0 plus wrap
    cmd(0, 3'b000);
    chk("R7 pd cleared", int'(power_down), 0);
    cmd(1, 0); cmd(2, 0);
    for (int i = 0; i < 5 * 128 + 3; i++) wr("R3", (i / 128) % 5, i % 128);
    // R2 back-to-back strobes give one pulse each
    cmd(1, 10); cmd(2, 1);
    @(negedge clk); wr_strobe = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 burst we", int'(ram_we), 1);
      chk("R2 burst col", int'(ram_col), 10 + i);
    end
    wr_strobe = 0;
    @(negedge clk);
    chk("R2 burst end", int'(ram_we), 0);
    // R4 vertical sweep across the column wrap
    cmd(0, 3'b010);
    chk("R7 v set", int'(vert_mode), 1);
    cmd(1, 125); cmd(2, 0);
    for (int i = 0; i < 5 * 6; i++) wr("R4", i % 5, (125 + i / 5) % 128);
    // R5 icon bank ignores direction bit
    cmd(1, 126); cmd(2, 5);
    for (int i = 0; i < 5; i++) wr("R5 v1", 5, (126 + i) % 128);
    cmd(0, 3'b001);
    chk("R7 im set", int'(icon_mode), 1);
    cmd(1, 127);
    for (int i = 0; i < 3; i++) wr("R5 v0", 5, (127 + i) % 128);
    // R6 invalid bank codes ignored
    cmd(1, 40); cmd(2, 3); cmd(2, 6); cmd(2, 7);
    wr("R6 bad bank", 3, 40);
    cmd(1, 127); cmd(2, 4);
    cmd(0, 3'b100);
    chk("R7 pd set", int'(power_down), 1);
    wr("R6 R7 load under pd", 4, 127);
    wr("R3 double wrap", 0, 0);
    // R8 stored fields and unused opcodes
    cmd(3, 2'b10); chk("R8 mux 1:34", int'(mux_rate), 2);
    cmd(3, 2'b01); chk("R8 mux 1:26", int'(mux_rate), 1);
    cmd(4, 2'b11); chk("R8 disp", int'(disp_mode), 3);
    cmd(1, 20); cmd(2, 2);
    cmd(5, 7'h7f); cmd(6, 7'h7f); cmd(7, 7'h7f);
    chk("R8 op5-7 mux", int'(mux_rate), 1);
    chk("R8 op5-7 disp", int'(disp_mode), 3);
    chk("R8 op5-7 pd", int'(power_down), 1);
    chk("R8 op5-7 v", int'(vert_mode), 0);
    wr("R8 op5-7 ptr", 2, 20);
    // R9 command and strobe together
    @(negedge clk);
    wr_strobe = 1; cmd_valid = 1; cmd_op = 3'd1; cmd_data = 7'd90;
    @(negedge clk);
    wr_strobe = 0; cmd_valid = 0;
    chk("R9 we", int'(ram_we), 1);
    chk("R9 old col", int'(ram_col), 21);
    wr("R9 cmd wins", 2, 90);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule